// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block takes one fast input clock and derives two output banks from it. Bank A carries several output pairs that all come from one shared divided clock. Bank B carries its own pair or pairs from a second divider. A single 3-bit select code sets the ratio of each bank. Each bank's ratio is one of 2, 4 or 5. Every ratio gives a 50% duty cycle, and divide-by-5 reaches that by combining a rising-edge counter with a falling-edge retiming flop.

Each output is a true/complement pair with a per-output drive flag. The drive flag stands in for the high-impedance state of a real output buffer. An active-high master reset parks all outputs with true high and complement low. Releasing the master reset restarts both banks phase-aligned. A select change is adopted only when a divider reaches its terminal count, so a running output never shows a runt pulse.

Top module: `cdb_dualbank`

## Requirements
- R1: The select code `sel_i` = {bit2,bit1,bit0} sets the (bank A, bank B) ratios as follows: 000→(2,2), 001→(2,5), 010→(4,2), 011→(4,5), 100→(5,2), 101→(5,4), 110→(2,4), 111→(4,4). The period of each bank equals its ratio in input cycles.
- R2: With ratio 2 or 4, the true output is high for exactly half the period, in whole input cycles.
- R3: With ratio 5, the true output is high for 2.5 input cycles and low for 2.5 input cycles.
- R4: All bank A pairs carry identical waveforms in every cycle.
- R5: While an output is driven, its complement is always the exact inverse of its true signal.
- R6: `mr_i` is sampled on the rising clock edge. From the first edge that samples it high, and for as long as it stays high, every true output is 1 and every complement is 0.
- R7: After `mr_i` is sampled low, the outputs stay high through that edge. Every true output of both banks falls together at the next rising edge. The first period after release uses the select code present at that edge.
- R8: With `oe_a_i` low, every bank A drive flag is 0 and both bank A signals are 0. With `oe_b_i` low, the same holds for bank B. Disabling one bank leaves the other bank's waveform unchanged.
- R9: A change of `sel_i` while running takes effect only at the end of a full period. No high or low interval differs from the half-period of either the old ratio or the new ratio.
- R10: `rst_n` is a synchronous active-low reset. While it is low, the outputs are parked exactly as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mr_i | input | 1 | Master reset, active high, parks the outputs |
| sel_i | input | 3 | Ratio select code for both banks |
| oe_a_i | input | 1 | Bank A output enable |
| oe_b_i | input | 1 | Bank B output enable |
| a_p_o | output | NA_PAIRS | Bank A true outputs |
| a_n_o | output | NA_PAIRS | Bank A complement outputs |
| a_drv_o | output | NA_PAIRS | Bank A drive flags (0 = high impedance) |
| b_p_o | output | NB_PAIRS | Bank B true outputs |
| b_n_o | output | NB_PAIRS | Bank B complement outputs |
| b_drv_o | output | NB_PAIRS | Bank B drive flags (0 = high impedance) |

## Verification
Release of the master reset and a ratio reload can land on the same rising edge. The release edge is itself a terminal count, so it reloads the ratio from the current select code. To provoke this, the bench changes `sel_i` to a new code while the block is parked. It then releases the reset and checks two things: that both banks fall on the same edge, and that the first full periods already show the new ratios. A second collision comes from changing the select code in the middle of a period. The bench records every high and low interval across that change and rejects any interval that matches neither ratio.

// File: rtl/cdb_pkg.sv
// Package: shared widths and the select-code decode for the dual-bank divider.
// Assumes ratios fit in RATIO_W bits; only the values 2, 4 and 5 are ever produced.
package cdb_pkg;
    localparam int SEL_W   = 3;
    localparam int RATIO_W = 3;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t a;
        ratio_t b;
    } ratio_pair_t;

    // Fixed select table: code -> (bank A ratio, bank B ratio)
    function automatic ratio_pair_t decode_sel(input logic [SEL_W-1:0] code);
        ratio_pair_t r;
        case (code)
            3'b000:  begin r.a = 3'd2; r.b = 3'd2; end
            3'b001:  begin r.a = 3'd2; r.b = 3'd5; end
            3'b010:  begin r.a = 3'd4; r.b = 3'd2; end
            3'b011:  begin r.a = 3'd4; r.b = 3'd5; end
            3'b100:  begin r.a = 3'd5; r.b = 3'd2; end
            3'b101:  begin r.a = 3'd5; r.b = 3'd4; end
            3'b110:  begin r.a = 3'd2; r.b = 3'd4; end
            default: begin r.a = 3'd4; r.b = 3'd4; end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cdb_divider.sv
// Divider: divides clk_i by the ratio held in ratio_q with a 50% duty cycle.
// The low phase comes first. Odd ratios AND in a falling-edge copy to stretch
// the low phase by half a cycle. A new ratio is loaded only at terminal count.
// While held, the state sits at terminal count with the output high, so the
// first edge after release starts a fresh period with a falling output.
// Assumes ratio_i is 2, 4 or 5.
module cdb_divider
    import cdb_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_n,
    input  logic   hold_i,
    input  ratio_t ratio_i,
    output logic   div_o
);
    localparam ratio_t ONE = ratio_t'(1);

    ratio_t cnt_q;
    ratio_t ratio_q;
    logic   qpos_q;
    logic   qneg_q;
    logic   term;

    assign term = (cnt_q == ratio_q - ONE);

    // Rising-edge counter: reload at terminal count, raise the output in the upper half
    always_ff @(posedge clk_i) begin
        if (!rst_n || hold_i) begin
            ratio_q <= ratio_i;
            cnt_q   <= ratio_i - ONE;
            qpos_q  <= 1'b1;
        end else if (term) begin
            ratio_q <= ratio_i;
            cnt_q   <= '0;
            qpos_q  <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + ONE;
            qpos_q  <= ((cnt_q + ONE) >= (ratio_q >> 1));
        end
    end

    // Falling-edge retime of the counter output, used for odd ratios
    always_ff @(negedge clk_i) begin
        if (!rst_n || hold_i) qneg_q <= 1'b1;
        else                  qneg_q <= qpos_q;
    end

    // Odd ratio: the rise is delayed by half a cycle
    always_comb begin
        div_o = ratio_q[0] ? (qpos_q & qneg_q) : qpos_q;
    end
endmodule

// File: rtl/cdb_pair_drv.sv
// Pair driver: turns one divided clock into a true/complement pair with a drive flag.
// Park forces true high. A disabled output drives both signals to 0, with the flag 0.
module cdb_pair_drv (
    input  logic clk_div_i,
    input  logic park_i,
    input  logic oe_i,
    output logic p_o,
    output logic n_o,
    output logic drv_o
);
    logic lvl;

    // Select the output level, then gate it by the enable
    always_comb begin
        lvl   = park_i | clk_div_i;
        p_o   = oe_i & lvl;
        n_o   = oe_i & ~lvl;
        drv_o = oe_i;
    end
endmodule

// File: rtl/cdb_dualbank.sv
// Top: a dual-bank selectable divider. One shared select code gives each bank a ratio.
// The master reset is registered once, so both its assertion and its release
// line up with clk_i. Bank A pairs share one divider; bank B has its own.
module cdb_dualbank
    import cdb_pkg::*;
#(
    parameter int NA_PAIRS = 2,
    parameter int NB_PAIRS = 1
) (
    input  logic                clk_i,
    input  logic                rst_n,
    input  logic                mr_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                oe_a_i,
    input  logic                oe_b_i,
    output logic [NA_PAIRS-1:0] a_p_o,
    output logic [NA_PAIRS-1:0] a_n_o,
    output logic [NA_PAIRS-1:0] a_drv_o,
    output logic [NB_PAIRS-1:0] b_p_o,
    output logic [NB_PAIRS-1:0] b_n_o,
    output logic [NB_PAIRS-1:0] b_drv_o
);
    logic        hold_q;
    ratio_pair_t ratios;
    logic        div_a;
    logic        div_b;

    // Register the master reset; the block reset also forces hold
    always_ff @(posedge clk_i) begin
        if (!rst_n) hold_q <= 1'b1;
        else        hold_q <= mr_i;
    end

    // Decode the shared select code
    always_comb begin
        ratios = decode_sel(sel_i);
    end

    cdb_divider u_div_a (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .hold_i  (hold_q),
        .ratio_i (ratios.a),
        .div_o   (div_a)
    );

    cdb_divider u_div_b (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .hold_i  (hold_q),
        .ratio_i (ratios.b),
        .div_o   (div_b)
    );

    for (genvar i = 0; i < NA_PAIRS; i++) begin : g_pair_a
        cdb_pair_drv u_drv (
            .clk_div_i (div_a),
            .park_i    (hold_q),
            .oe_i      (oe_a_i),
            .p_o       (a_p_o[i]),
            .n_o       (a_n_o[i]),
            .drv_o     (a_drv_o[i])
        );
    end

    for (genvar j = 0; j < NB_PAIRS; j++) begin : g_pair_b
        cdb_pair_drv u_drv (
            .clk_div_i (div_b),
            .park_i    (hold_q),
            .oe_i      (oe_b_i),
            .p_o       (b_p_o[j]),
            .n_o       (b_n_o[j]),
            .drv_o     (b_drv_o[j])
        );
    end
endmodule

// File: rtl/cdb_dualbank_chk.sv
// Checker: port-level properties of the dual-bank divider, bound to the top.
module cdb_dualbank_chk #(
    parameter int NA_PAIRS = 2,
    parameter int NB_PAIRS = 1
) (
    input logic                clk_i,
    input logic                rst_n,
    input logic                mr_i,
    input logic                oe_a_i,
    input logic                oe_b_i,
    input logic [NA_PAIRS-1:0] a_p_o,
    input logic [NA_PAIRS-1:0] a_n_o,
    input logic [NA_PAIRS-1:0] a_drv_o,
    input logic [NB_PAIRS-1:0] b_p_o,
    input logic [NB_PAIRS-1:0] b_n_o,
    input logic [NB_PAIRS-1:0] b_drv_o
);
    AST_BANK_A_SAME: assert property (@(posedge clk_i) disable iff (!rst_n)
        oe_a_i |-> (a_p_o == {NA_PAIRS{a_p_o[0]}})); // R4

    AST_COMP_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_n)
        (oe_a_i && oe_b_i) |-> ((a_n_o == ~a_p_o) && (b_n_o == ~b_p_o))); // R5

    AST_PARKED: assert property (@(posedge clk_i) disable iff (!rst_n)
        ($past(mr_i) && oe_a_i && oe_b_i) |-> ((&a_p_o) && !(|a_n_o) && (&b_p_o) && !(|b_n_o))); // R6

    AST_RELEASE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!mr_i && !$past(mr_i) && !$past(mr_i, 2) && $past(mr_i, 3) && oe_a_i && oe_b_i)
        |-> (!(|a_p_o) && !(|b_p_o))); // R7

    AST_HIZ_A: assert property (@(posedge clk_i) disable iff (!rst_n)
        !oe_a_i |-> (!(|a_drv_o) && !(|a_p_o) && !(|a_n_o))); // R8

    AST_HIZ_B: assert property (@(posedge clk_i) disable iff (!rst_n)
        !oe_b_i |-> (!(|b_drv_o) && !(|b_p_o) && !(|b_n_o))); // R8
endmodule

bind cdb_dualbank cdb_dualbank_chk #(
    .NA_PAIRS (NA_PAIRS),
    .NB_PAIRS (NB_PAIRS)
) u_chk (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .mr_i    (mr_i),
    .oe_a_i  (oe_a_i),
    .oe_b_i  (oe_b_i),
    .a_p_o   (a_p_o),
    .a_n_o   (a_n_o),
    .a_drv_o (a_drv_o),
    .b_p_o   (b_p_o),
    .b_n_o   (b_n_o),
    .b_drv_o (b_drv_o)
);

// File: tb/tb_cdb_dualbank.sv
`timescale 1ns/100ps
// Directed bench for the dual-bank divider. Outputs are sampled 1 ns after
// every clock edge, i.e. once per half cycle. Widths are counted in half cycles.
module tb_cdb_dualbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mr = 1'b0;
    logic [2:0] sel = 3'b000;
    logic       oe_a = 1'b1;
    logic       oe_b = 1'b1;
    logic [1:0] a_p, a_n, a_drv;
    logic [0:0] b_p, b_n, b_drv;

    int vectors = 0;
    int miscomp = 0;
    int inv_bad = 0;
    int pair_bad = 0;

    always #2 clk = ~clk;

    cdb_dualbank dut (
        .clk_i(clk), .rst_n(rst_n), .mr_i(mr), .sel_i(sel),
        .oe_a_i(oe_a), .oe_b_i(oe_b),
        .a_p_o(a_p), .a_n_o(a_n), .a_drv_o(a_drv),
        .b_p_o(b_p), .b_n_o(b_n), .b_drv_o(b_drv)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_a(input logic [2:0] s);
        case (s)
            3'b000: return 2; 3'b001: return 2; 3'b010: return 4; 3'b011: return 4;
            3'b100: return 5; 3'b101: return 5; 3'b110: return 2; default: return 4;
        endcase
    endfunction

    function automatic int ratio_b(input logic [2:0] s);
        case (s)
            3'b000: return 2; 3'b001: return 5; 3'b010: return 2; 3'b011: return 5;
            3'b100: return 2; 3'b101: return 4; 3'b110: return 4; default: return 4;
        endcase
    endfunction

    // Advance half a cycle, then return the bank's true level and tally side checks
    task automatic step(input bit bank_b, output bit lvl);
        @(clk);
        #1;
        if (a_drv[0] && (a_n !== ~a_p)) inv_bad++;
        if (b_drv[0] && (b_n !== ~b_p)) inv_bad++;
        if (a_p[0] !== a_p[1]) pair_bad++;
        lvl = bank_b ? b_p[0] : a_p[0];
    endtask

    // Measure the high width and period of one bank, in half cycles
    task automatic measure(input bit bank_b, output int hi, output int per);
        bit prev, cur, found;
        int lo;
        hi = 0; lo = 0; found = 0;
        step(bank_b, prev);
        for (int i = 0; i < 40 && !found; i++) begin
            step(bank_b, cur);
            if (!prev && cur) found = 1;
            prev = cur;
        end
        if (found) begin
            hi = 1;
            for (int i = 0; i < 40; i++) begin
                step(bank_b, cur);
                if (cur) hi++; else break;
            end
            lo = 1;
            for (int i = 0; i < 40; i++) begin
                step(bank_b, cur);
                if (!cur) lo++; else break;
            end
        end
        per = hi + lo;
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk);
        #1;
        chk(a_p == 2'b11 && a_n == 2'b00 && b_p == 1'b1 && b_n == 1'b0, "R10 parked under rst_n",
            {a_p, b_p}, 3'b111);
        chk(a_drv == 2'b11 && b_drv == 1'b1, "R10 drive flags", {a_drv, b_drv}, 3'b111);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_sweep;
        int hi, per;
        for (int c = 0; c < 8; c++) begin
            sel = 3'(c);
            repeat (12) @(posedge clk);
            measure(1'b0, hi, per);
            chk(per == 2 * ratio_a(sel), "R1 bank A period", per, 2 * ratio_a(sel));
            chk(hi == ratio_a(sel), ratio_a(sel) == 5 ? "R3 bank A high" : "R2 bank A high",
                hi, ratio_a(sel));
            measure(1'b1, hi, per);
            chk(per == 2 * ratio_b(sel), "R1 bank B period", per, 2 * ratio_b(sel));
            chk(hi == ratio_b(sel), ratio_b(sel) == 5 ? "R3 bank B high" : "R2 bank B high",
                hi, ratio_b(sel));
        end
        chk(pair_bad == 0, "R4 bank A pairs identical", pair_bad, 0);
        chk(inv_bad == 0, "R5 complement inverse", inv_bad, 0);
    endtask

    task automatic t_master_reset;
        int hi, per;
        sel = 3'b101;
        repeat (9) @(posedge clk);
        @(negedge clk);
        mr = 1'b1;
        @(posedge clk);
        #1;
        chk(a_p == 2'b11 && a_n == 2'b00 && b_p == 1'b1 && b_n == 1'b0, "R6 parked at first edge",
            {a_p, a_n, b_p, b_n}, 6'b110010);
        sel = 3'b011;
        repeat (5) @(posedge clk);
        #1;
        chk(a_p == 2'b11 && a_n == 2'b00 && b_p == 1'b1 && b_n == 1'b0, "R6 parked while held",
            {a_p, a_n, b_p, b_n}, 6'b110010);
        @(negedge clk);
        mr = 1'b0;
        @(posedge clk);
        #1;
        chk(a_p == 2'b11 && b_p == 1'b1, "R7 high through release edge", {a_p, b_p}, 3'b111);
        @(posedge clk);
        #1;
        chk(a_p == 2'b00 && b_p == 1'b0, "R7 both banks fall together", {a_p, b_p}, 3'b000);
        measure(1'b0, hi, per);
        chk(per == 8, "R7 bank A new ratio after release", per, 8);
        measure(1'b1, hi, per);
        chk(per == 10, "R7 bank B new ratio after release", per, 10);
    endtask

    task automatic t_enable;
        int hi, per;
        sel = 3'b000;
        repeat (6) @(posedge clk);
        @(negedge clk);
        oe_a = 1'b0;
        #1;
        chk(a_drv == 2'b00 && a_p == 2'b00 && a_n == 2'b00, "R8 bank A high impedance",
            {a_drv, a_p, a_n}, 0);
        measure(1'b1, hi, per);
        chk(per == 4 && b_drv == 1'b1, "R8 bank B unaffected", per, 4);
        @(negedge clk);
        oe_a = 1'b1;
        oe_b = 1'b0;
        #1;
        chk(b_drv == 1'b0 && b_p == 1'b0 && b_n == 1'b0, "R8 bank B high impedance",
            {b_drv, b_p, b_n}, 0);
        measure(1'b0, hi, per);
        chk(per == 4 && a_drv == 2'b11, "R8 bank A unaffected", per, 4);
        @(negedge clk);
        oe_b = 1'b1;
    endtask

    // Record a run of samples across a select change and judge every interior interval
    task automatic t_sel_change(input logic [2:0] from_s, input logic [2:0] to_s, input bit bank_b);
        bit smp [64];
        int bad, run, runs, h_old, h_new, hi, per;
        sel = from_s;
        repeat (12) @(posedge clk);
        h_old = bank_b ? ratio_b(from_s) : ratio_a(from_s);
        h_new = bank_b ? ratio_b(to_s) : ratio_a(to_s);
        for (int i = 0; i < 64; i++) begin
            if (i == 23) sel = to_s;
            step(bank_b, smp[i]);
        end
        bad = 0; run = 1; runs = 0;
        for (int i = 1; i < 64; i++) begin
            if (smp[i] == smp[i-1]) run++;
            else begin
                if (runs > 0 && run != h_old && run != h_new) bad++;
                runs++;
                run = 1;
            end
        end
        chk(bad == 0, "R9 no runt across select change", bad, 0);
        measure(bank_b, hi, per);
        chk(per == 2 * h_new, "R9 new ratio adopted", per, 2 * h_new);
    endtask

    initial begin
        #400000;
        miscomp++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_master_reset();
        t_enable();
        t_sel_change(3'b000, 3'b100, 1'b0);
        t_sel_change(3'b001, 3'b000, 1'b1);
        t_sel_change(3'b111, 3'b011, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule